// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets a synchronous host perform single reads and writes on an external asynchronous static RAM of 16K words by 4 bits. The RAM has three active-low strobes: chip enable, write enable and output enable. The host side uses a request/ready handshake. The host presents a request with a write flag, a 14-bit address and 4-bit write data. Read data comes back with a one-cycle valid strobe. On the memory side the block drives the address and the strobes, and splits the bidirectional data pins into an output value, an input value and a driver enable.

Every timing interval is a parameter counted in clock cycles, so one design fits any speed grade of the RAM. These intervals are the read access, the write pulse, the data hold after the write ends, and the read-to-write turnaround. A write is the overlap of chip enable and write enable low, and both rise together to end it. The write data is held on the bus until after that edge. Output enable stays high for the whole write, so the RAM and the host driver never fight over the pins. While no access is running, chip enable stays high and the RAM can fall into its low-power standby.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, sram_ce_n, sram_we_n and sram_oe_n are 1, sram_dq_t is 0, host_ready is 1 and host_rvalid is 0.
- R2: A request with host_wr=0 that is accepted at a rising edge holds sram_ce_n=0, sram_oe_n=0 and sram_we_n=1 for exactly RD_CYC cycles, starting at that edge.
- R3: At the edge that ends a read, host_rdata takes the value of sram_dq_i, and host_rvalid is 1 for exactly one cycle.
- R4: A request with host_wr=1 holds sram_ce_n=0 and sram_we_n=0 for exactly WP_CYC cycles (at least 2), and sram_oe_n stays 1 throughout.
- R5: sram_dq_t is 0 in the first cycle of the write pulse and 1 in each later cycle of it. It stays 1 for exactly DH_CYC cycles after sram_we_n rises, and sram_dq_o holds the write data during that whole time.
- R6: sram_dq_t is never 1 while sram_oe_n is 0.
- R7: After a read ends, host_ready stays 0 and sram_dq_t stays 0 for exactly TA_CYC cycles before host_ready returns to 1.
- R8: sram_a holds the address of the accepted request for as long as sram_ce_n is 0 and during the data-hold cycles.
- R9: host_ready is 1 only while no access is running. While host_ready is 0, host_req has no effect: no memory access starts and no location changes.
- R10: While no access is running, sram_ce_n stays 1.
- R11: All 14 address bits reach the RAM, so address 0 and address 16383 are separate locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request, taken while host_ready is 1 |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 14 | Word address |
| host_wdata | input | 4 | Write data |
| host_ready | output | 1 | Idle and able to accept a request |
| host_rdata | output | 4 | Read data |
| host_rvalid | output | 1 | One-cycle strobe marking host_rdata valid |
| sram_a | output | 14 | RAM address pins |
| sram_ce_n | output | 1 | RAM chip enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_dq_o | output | 4 | Value driven onto the RAM data pins |
| sram_dq_i | input | 4 | Value sampled from the RAM data pins |
| sram_dq_t | output | 1 | Enable for the host data driver |

## Verification
Two events can land on the same clock edge. The edge that ends a read also captures the read data and starts the turnaround. The edge that ends a write pulse also raises chip enable and write enable while the data driver stays on. The bench models the RAM so that it stores a word only at the rising edge of the write-ending strobe, and only if the data driver is still enabled at that moment. It then reads the word back. After each read it counts the turnaround cycles, and a write issued right after a read must not find the driver on early. A request raised while the block is busy must leave the target location unchanged, and the bench confirms this by a later read.

// File: rtl/asram_pkg.sv
package asram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD    = 3'd1,
    ST_RTURN = 3'd2,
    ST_WPUL  = 3'd3,
    ST_WHOLD = 3'd4
  } seq_state_t;

  function automatic int unsigned at_least(input int unsigned v, input int unsigned lo);
    return (v < lo) ? lo : v;
  endfunction
endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= '0;
    else if (load)      cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
  parameter int AW = 14,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_wdata,
  input  logic          capture,
  input  logic [DW-1:0] pin_data,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q,
  output logic          rvalid_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= in_addr;
      wdata_q <= in_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture;
      if (capture) rdata_q <= pin_data;
    end
  end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int AW     = 14,
  parameter int DW     = 4,
  parameter int RD_CYC = 2,
  parameter int WP_CYC = 2,
  parameter int DH_CYC = 1,
  parameter int TA_CYC = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_req,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          host_ready,
  output logic [DW-1:0] host_rdata,
  output logic          host_rvalid,
  output logic [AW-1:0] sram_a,
  output logic          sram_ce_n,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic [DW-1:0] sram_dq_o,
  input  logic [DW-1:0] sram_dq_i,
  output logic          sram_dq_t
);
  // Effective counts: the write pulse needs one cycle before the driver turns on.
  localparam int unsigned RD_E = at_least(RD_CYC, 1);
  localparam int unsigned WP_E = at_least(WP_CYC, 2);
  localparam int unsigned DH_E = at_least(DH_CYC, 1);
  localparam int unsigned TA_E = at_least(TA_CYC, 1);
  localparam int unsigned MAX1 = (RD_E > WP_E) ? RD_E : WP_E;
  localparam int unsigned MAX2 = (DH_E > TA_E) ? DH_E : TA_E;
  localparam int unsigned MAXC = (MAX1 > MAX2) ? MAX1 : MAX2;
  localparam int CW = $clog2(MAXC + 1);

  seq_state_t    st_q, st_d;
  logic          t_load, t_zero;
  logic [CW-1:0] t_val;
  logic          accept, capture;

  logic ce_n_q, we_n_q, oe_n_q, dq_t_q, ready_q;

  assign accept  = (st_q == ST_IDLE) && host_req;
  assign capture = (st_q == ST_RD) && t_zero;

  always_comb begin
    st_d   = st_q;
    t_load = 1'b0;
    t_val  = '0;
    unique case (st_q)
      ST_IDLE: if (host_req) begin
        t_load = 1'b1;
        if (host_wr) begin
          st_d  = ST_WPUL;
          t_val = CW'(WP_E - 1);
        end else begin
          st_d  = ST_RD;
          t_val = CW'(RD_E - 1);
        end
      end
      ST_RD: if (t_zero) begin
        st_d   = ST_RTURN;
        t_load = 1'b1;
        t_val  = CW'(TA_E - 1);
      end
      ST_RTURN: if (t_zero) st_d = ST_IDLE;
      ST_WPUL: if (t_zero) begin
        st_d   = ST_WHOLD;
        t_load = 1'b1;
        t_val  = CW'(DH_E - 1);
      end
      ST_WHOLD: if (t_zero) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      ce_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_t_q  <= 1'b0;
      ready_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      ce_n_q  <= !((st_d == ST_RD) || (st_d == ST_WPUL));
      we_n_q  <= !(st_d == ST_WPUL);
      oe_n_q  <= !(st_d == ST_RD);
      dq_t_q  <= ((st_d == ST_WPUL) && (st_q == ST_WPUL)) || (st_d == ST_WHOLD);
      ready_q <= (st_d == ST_IDLE);
    end
  end

  asram_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  asram_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst(rst), .accept(accept), .in_addr(host_addr),
    .in_wdata(host_wdata), .capture(capture), .pin_data(sram_dq_i),
    .addr_q(sram_a), .wdata_q(sram_dq_o), .rdata_q(host_rdata),
    .rvalid_q(host_rvalid)
  );

  assign sram_ce_n  = ce_n_q;
  assign sram_we_n  = we_n_q;
  assign sram_oe_n  = oe_n_q;
  assign sram_dq_t  = dq_t_q;
  assign host_ready = ready_q;
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int AW = 14,
  parameter int DW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          host_ready,
  input logic          host_rvalid,
  input logic [AW-1:0] sram_a,
  input logic          sram_ce_n,
  input logic          sram_we_n,
  input logic          sram_oe_n,
  input logic [DW-1:0] sram_dq_o,
  input logic          sram_dq_t
);
  // R6: the RAM output and the host driver never overlap
  a_r6_no_contention: assert property (@(posedge clk) disable iff (rst)
    !(sram_dq_t && !sram_oe_n));

  // R4: a write pulse is always chip-selected with outputs off
  a_r4_write_qualified: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> (!sram_ce_n && sram_oe_n));

  // R5: the driver is off as write enable falls and on one cycle later
  a_r5_drive_after_we: assert property (@(posedge clk) disable iff (rst)
    $fell(sram_we_n) |-> (!sram_dq_t ##1 sram_dq_t));

  // R5: data is held across the edge that ends the write
  a_r5_hold_at_end: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> (sram_dq_t && $stable(sram_dq_o)));

  // R8: the address does not move during a selected access
  a_r8_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_a));

  // R3: the read strobe lasts one cycle
  a_r3_rvalid_pulse: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |=> !host_rvalid);

  // R9, R10: when ready, the RAM is deselected and undriven
  a_r9_ready_idle: assert property (@(posedge clk) disable iff (rst)
    host_ready |-> (sram_ce_n && !sram_dq_t));

  // R7: no driver in the cycle after output enable rises
  a_r7_turnaround: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_oe_n) |=> !sram_dq_t);
endmodule

bind asram_ctrl asram_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .host_ready(host_ready), .host_rvalid(host_rvalid),
  .sram_a(sram_a), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
  .sram_oe_n(sram_oe_n), .sram_dq_o(sram_dq_o), .sram_dq_t(sram_dq_t)
);

// File: tb/tb_asram_ctrl.sv
module tb_asram_ctrl;
  localparam int AW = 14, DW = 4;
  localparam int RD = 4, WP = 3, DH = 2, TA = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic host_req = 1'b0, host_wr = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic host_ready, host_rvalid;
  logic [DW-1:0] host_rdata;
  logic [AW-1:0] sram_a;
  logic sram_ce_n, sram_we_n, sram_oe_n, sram_dq_t;
  logic [DW-1:0] sram_dq_o, sram_dq_i;

  int checks = 0, errors = 0, cyc = 0;
  logic [DW-1:0] ram [int];
  logic [DW-1:0] shadow [int];

  always #5 clk = ~clk;

  asram_ctrl #(.AW(AW), .DW(DW), .RD_CYC(RD), .WP_CYC(WP), .DH_CYC(DH), .TA_CYC(TA)) dut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .sram_a(sram_a),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_dq_o(sram_dq_o), .sram_dq_i(sram_dq_i), .sram_dq_t(sram_dq_t)
  );

  // RAM model: drives the pins only when selected for reading
  always @* begin
    if (!sram_ce_n && !sram_oe_n && sram_we_n)
      sram_dq_i = ram.exists(int'(sram_a)) ? ram[int'(sram_a)] : 4'h0;
    else
      sram_dq_i = 4'h0;
  end

  wire wr_end = sram_ce_n | sram_we_n;
  always @(posedge wr_end) begin
    if (!rst && cyc > 2) begin
      checks++;
      if (!sram_dq_t) begin
        errors++;
        $display("FAIL R5 driver at write end: got %0b exp 1", sram_dq_t);
      end
      ram[int'(sram_a)] = sram_dq_o;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h exp %0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles exp <= 20000", cyc);
      finish_up();
    end
  end

  // contention monitor
  int contention = 0;
  always @(negedge clk) if (!rst && sram_dq_t && !sram_oe_n) contention++;

  function automatic logic [DW-1:0] exp_word(input int a);
    return shadow.exists(a) ? shadow[a] : 4'h0;
  endfunction

  task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0; host_addr = ~a; host_wdata = ~d;
  endtask

  task automatic t_read(input logic [AW-1:0] a, input string tag);
    int n = 0, turn = 0;
    logic [DW-1:0] e = exp_word(int'(a));
    issue(1'b0, a, 4'h0);
    while (!sram_ce_n) begin
      if (sram_oe_n || !sram_we_n || sram_a != a) begin
        errors++; checks++;
        $display("FAIL R2/R8 %s strobes: oe %0b we %0b a %0h exp 0 1 %0h",
                 tag, sram_oe_n, sram_we_n, sram_a, a);
      end
      n++;
      @(negedge clk);
    end
    check({"R2 read length ", tag}, n, RD);
    check({"R3 rvalid ", tag}, host_rvalid, 1);
    check({"R3 rdata ", tag}, host_rdata, e);
    while (!host_ready && turn < 20) begin
      if (sram_dq_t) begin
        errors++; checks++;
        $display("FAIL R7 driver in turnaround: got 1 exp 0");
      end
      turn++;
      @(negedge clk);
    end
    check({"R7 turnaround ", tag}, turn, TA);
    check({"R3 rvalid single ", tag}, host_rvalid, 0);
  endtask

  task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    int n = 0, hold = 0;
    issue(1'b1, a, d);
    check({"R5 driver off first pulse cycle ", tag}, sram_dq_t, 0);
    while (!sram_we_n) begin
      if (sram_ce_n || !sram_oe_n || sram_a != a || (n > 0 && (!sram_dq_t || sram_dq_o != d))) begin
        errors++; checks++;
        $display("FAIL R4/R5 %s pulse: ce %0b oe %0b t %0b dq %0h exp 0 1 1 %0h",
                 tag, sram_ce_n, sram_oe_n, sram_dq_t, sram_dq_o, d);
      end
      n++;
      @(negedge clk);
    end
    check({"R4 pulse length ", tag}, n, WP);
    while (sram_dq_t && hold < 20) begin
      if (sram_dq_o != d || sram_a != a) begin
        errors++; checks++;
        $display("FAIL R5/R8 %s hold: dq %0h a %0h exp %0h %0h", tag, sram_dq_o, sram_a, d, a);
      end
      hold++;
      @(negedge clk);
    end
    check({"R5 hold length ", tag}, hold, DH);
    check({"R9 ready after write ", tag}, host_ready, 1);
    shadow[int'(a)] = d;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 ce_n", sram_ce_n, 1);
    check("R1 we_n", sram_we_n, 1);
    check("R1 oe_n", sram_oe_n, 1);
    check("R1 dq_t", sram_dq_t, 0);
    check("R1 ready", host_ready, 1);
    check("R1 rvalid", host_rvalid, 0);
  endtask

  task automatic t_busy_ignored();
    // start a read, then pulse a write request while busy
    @(negedge clk);
    host_req = 1'b1; host_wr = 1'b0; host_addr = 14'h0123;
    @(negedge clk);
    host_req = 1'b1; host_wr = 1'b1; host_addr = 14'h0055; host_wdata = 4'hF;
    @(negedge clk);
    host_req = 1'b0;
    repeat (RD + TA + 2) @(negedge clk);
    check("R9 no access started while busy", sram_we_n, 1);
    check("R10 idle deselected", sram_ce_n, 1);
    t_read(14'h0055, "R9 busy target unchanged");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write(14'h0000, 4'h5, "R11 low");
    t_write(14'h3FFF, 4'hA, "R11 high");
    t_read(14'h0000, "R11 low");
    t_read(14'h3FFF, "R11 high");
    t_write(14'h0055, 4'h3, "w55");
    t_read(14'h0055, "r55");
    t_write(14'h2AAA, 4'hC, "R7 after read");
    t_read(14'h2AAA, "r2aaa");
    t_read(14'h1111, "unwritten");
    t_busy_ignored();
    repeat (5) @(negedge clk);
    check("R10 idle ce_n", sram_ce_n, 1);
    check("R6 no contention", contention, 0);
    finish_up();
  end
endmodule